// File: doc/BRIEF.md
# HDLC Receive Address Filter

This block sits in an HDLC receive path between the zero-bit-removal stage and the receive FIFO. It takes one destuffed byte at a time, with markers for the first and last byte of each frame. It decides, frame by frame, whether the bytes go on to the FIFO. When address filtering is on, a frame is kept only if its address field matches a programmed station address or the all-call address. The all-call address is all ones in every compared bit. A rejected frame causes one discard pulse and no FIFO writes. The filter then waits for the next opening flag.

There are two address formats. In the single-byte seven-bit format, only bits 7..1 of the first byte are compared, and bit 0 of that byte must be 1. In the two-byte format, both address bytes must match the same target: either the station address (low byte first) or all-call. In that format the first byte is held in a staging register until the second byte has been checked. After that, the output trails the input by one byte. The block also handles three receiver controls. A receive enable that takes effect at once when set and only at a frame boundary when cleared. An external receive clock-enable that gates incoming bytes. A FIFO reset that empties the FIFO view and mutes the receiver until the next opening flag.

The input must leave at least one idle cycle after a last-of-frame byte, since a closing flag always takes several bit times.

Top module: `hdlc_addr_filter`

## Requirements
- R1: After reset `out_valid`, `out_eof`, `frame_drop` and `fifo_flush` are low, and `rx_active` follows `rx_enable`.
- R2: With `addr_rec_en` low, every byte of a frame started while enabled appears on `out_data` one cycle after it is taken. The last byte carries `out_eof`.
- R3: In two-byte mode (`addr_rec_en`=1, `seven_mode`=0), a frame is kept when byte 0 equals `uniq_addr[7:0]` and byte 1 equals `uniq_addr[15:8]`, or when both bytes are 8'hFF. Byte 0 comes out one cycle after byte 1 is taken. Each later byte comes out one cycle after the next byte is taken. The last byte comes out, with `out_eof`, two cycles after it is taken.
- R4: In seven-bit mode (`addr_rec_en`=1, `seven_mode`=1), a frame is kept when bit 0 of byte 0 is 1 and bits 7..1 equal `uniq_addr[7:1]` or 7'h7F. A kept frame passes with one cycle of latency. A byte 0 with bit 0 clear is rejected even when its upper bits match.
- R5: A rejected frame pulses `frame_drop` for one cycle, one cycle after the deciding byte. It produces no `out_valid` for the rest of that frame. `frame_drop` and `out_valid` are never high together.
- R6: In two-byte mode, a frame whose byte 0 matches the station address and whose byte 1 is 8'hFF is rejected. A frame whose byte 0 matches neither target is rejected at byte 0.
- R7: When `rx_enable` is cleared during a frame, that frame still passes completely. `rx_active` goes low in the cycle after its last byte is taken. Frames that open while disabled give no output.
- R8: When `rx_enable` is set and no FIFO reset is pending, `rx_active` is high in the same cycle.
- R9: A `fifo_rst` cycle gives a `fifo_flush` pulse in the next cycle. It ends the current frame with no further output. It holds `rx_active` low and ignores non-opening bytes until an opening byte is taken with `rx_enable` high. That opening byte is processed normally.
- R10: A byte presented while `rx_clk_en` is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_enable | input | 1 | Receive enable |
| rx_clk_en | input | 1 | External receive clock-enable; gates `in_valid` |
| fifo_rst | input | 1 | Receive FIFO reset request |
| addr_rec_en | input | 1 | Address filtering on |
| seven_mode | input | 1 | Single-byte seven-bit address format |
| uniq_addr | input | 2*BYTE_W | Station address; byte 0 in the low half |
| in_valid | input | 1 | A destuffed byte is present |
| in_data | input | BYTE_W | Destuffed byte |
| in_sof | input | 1 | Byte is the first after an opening flag |
| in_eof | input | 1 | Byte is the last before a closing flag |
| out_valid | output | 1 | FIFO write strobe |
| out_data | output | BYTE_W | Byte to write |
| out_eof | output | 1 | Written byte ends the frame |
| frame_drop | output | 1 | Frame discarded by the address check |
| fifo_flush | output | 1 | Empty the FIFO occupancy |
| rx_active | output | 1 | Receiver active |

## Verification
All registered results are due one cycle after the input edge that causes them. The one exception is the two-byte mode, where data trails by one byte and the last byte comes out two cycles after it is taken. `rx_active` is combinational and is due in the same cycle as `rx_enable`. The bench drives inputs shortly after each rising edge and runs a queue-based reference model on that same edge. It compares every output at the falling edge, so each expected value is checked in exactly the cycle it is due. Per-scenario byte, discard and flush counts then confirm the overall outcome of each frame.

// File: rtl/hdlc_af_pkg.sv
package hdlc_af_pkg;
   typedef enum logic [2:0] {
      FS_IDLE,
      FS_WAIT2,
      FS_PASS1,
      FS_PASS2,
      FS_DROP
   } fstate_t;
endpackage

// File: rtl/adf_match.sv
module adf_match #(
   parameter int BYTE_W   = 8,
   parameter bit SEVEN_EN = 1'b1
) (
   input  logic                  addr_rec_en,
   input  logic                  seven_mode,
   input  logic [2*BYTE_W-1:0]   uniq_addr,
   input  logic [BYTE_W-1:0]     d,
   output logic                  one_byte,
   output logic                  first_ok,
   output logic                  lo_uniq,
   output logic                  lo_all,
   output logic                  hi_uniq,
   output logic                  hi_all
);
   localparam int HI_LSB = BYTE_W;

   logic seven_eff;
   logic seven_hit;

   generate
      if (SEVEN_EN) begin : g_seven
         assign seven_eff = seven_mode;
      end else begin : g_no_seven
         logic unused_seven;
         assign unused_seven = seven_mode;
         assign seven_eff    = 1'b0;
      end
   endgenerate

   always_comb begin
      lo_uniq   = (d == uniq_addr[BYTE_W-1:0]);
      lo_all    = &d;
      hi_uniq   = (d == uniq_addr[HI_LSB +: BYTE_W]);
      hi_all    = &d;
      seven_hit = d[0] & ((d[BYTE_W-1:1] == uniq_addr[BYTE_W-1:1]) | (&d[BYTE_W-1:1]));
      one_byte  = ~addr_rec_en | seven_eff;
      if (!addr_rec_en)   first_ok = 1'b1;
      else if (seven_eff) first_ok = seven_hit;
      else                first_ok = lo_uniq | lo_all;
   end
endmodule

// File: rtl/adf_ctrl.sv
module adf_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic fifo_rst,
   input  logic start,
   input  logic rx_enable,
   input  logic busy,
   output logic hold_q,
   output logic rx_active
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        hold_q <= 1'b0;
      else if (fifo_rst) hold_q <= 1'b1;
      else if (start)    hold_q <= 1'b0;
   end

   assign rx_active = ~hold_q & (rx_enable | busy);

   // R9: a FIFO reset mutes the receiver in the following cycle
   a_r9_muted_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_rst |=> !rx_active);
endmodule

// File: rtl/adf_frame.sv
module adf_frame
   import hdlc_af_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              rx_clk_en,
   input  logic              fifo_rst,
   input  logic              rx_enable,
   input  logic              hold_q,
   input  logic              in_sof,
   input  logic              in_eof,
   input  logic [BYTE_W-1:0] in_data,
   input  logic              one_byte,
   input  logic              first_ok,
   input  logic              lo_uniq,
   input  logic              lo_all,
   input  logic              hi_uniq,
   input  logic              hi_all,
   output logic              out_valid,
   output logic [BYTE_W-1:0] out_data,
   output logic              out_eof,
   output logic              frame_drop,
   output logic              fifo_flush,
   output logic              busy,
   output logic              start
);
   fstate_t           st;
   logic [BYTE_W-1:0] stage;
   logic              mu_q, ma_q, flush_q;
   logic              take, cont, pair_ok;

   always_comb begin
      take    = in_valid & rx_clk_en & ~fifo_rst & ~flush_q;
      start   = take & in_sof & rx_enable;
      cont    = take & ~in_sof & ~hold_q & (st != FS_IDLE);
      pair_ok = (mu_q & hi_uniq) | (ma_q & hi_all);
      busy    = (st != FS_IDLE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= FS_IDLE;
         stage      <= '0;
         mu_q       <= 1'b0;
         ma_q       <= 1'b0;
         flush_q    <= 1'b0;
         out_valid  <= 1'b0;
         out_data   <= '0;
         out_eof    <= 1'b0;
         frame_drop <= 1'b0;
         fifo_flush <= 1'b0;
      end else begin
         out_valid  <= 1'b0;
         out_eof    <= 1'b0;
         frame_drop <= 1'b0;
         fifo_flush <= 1'b0;
         flush_q    <= 1'b0;
         if (fifo_rst) begin
            st         <= FS_IDLE;
            fifo_flush <= 1'b1;
         end else if (flush_q) begin
            out_valid <= 1'b1;
            out_data  <= stage;
            out_eof   <= 1'b1;
         end else if (start) begin
            if (one_byte) begin
               if (first_ok) begin
                  out_valid <= 1'b1;
                  out_data  <= in_data;
                  out_eof   <= in_eof;
                  st        <= in_eof ? FS_IDLE : FS_PASS1;
               end else begin
                  frame_drop <= 1'b1;
                  st         <= in_eof ? FS_IDLE : FS_DROP;
               end
            end else if ((lo_uniq | lo_all) && !in_eof) begin
               stage <= in_data;
               mu_q  <= lo_uniq;
               ma_q  <= lo_all;
               st    <= FS_WAIT2;
            end else begin
               frame_drop <= 1'b1;
               st         <= in_eof ? FS_IDLE : FS_DROP;
            end
         end else if (take && in_sof) begin
            st <= FS_IDLE;
         end else if (cont) begin
            case (st)
               FS_PASS1: begin
                  out_valid <= 1'b1;
                  out_data  <= in_data;
                  out_eof   <= in_eof;
                  if (in_eof) st <= FS_IDLE;
               end
               FS_WAIT2: begin
                  if (pair_ok) begin
                     out_valid <= 1'b1;
                     out_data  <= stage;
                     stage     <= in_data;
                     flush_q   <= in_eof;
                     st        <= in_eof ? FS_IDLE : FS_PASS2;
                  end else begin
                     frame_drop <= 1'b1;
                     st         <= in_eof ? FS_IDLE : FS_DROP;
                  end
               end
               FS_PASS2: begin
                  out_valid <= 1'b1;
                  out_data  <= stage;
                  stage     <= in_data;
                  flush_q   <= in_eof;
                  if (in_eof) st <= FS_IDLE;
               end
               FS_DROP: if (in_eof) st <= FS_IDLE;
               default: st <= FS_IDLE;
            endcase
         end
      end
   end

   // R5: a discard pulse never coincides with a FIFO write
   a_r5_drop_silent: assert property (@(posedge clk) disable iff (!rst_n)
      frame_drop |-> !out_valid);
   // R9: a FIFO reset gives a flush and no write in the next cycle
   a_r9_flush_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_rst |=> (fifo_flush && !out_valid));
   // R10: a gated byte leaves the outputs quiet
   a_r10_gated_byte: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_clk_en && !flush_q && !fifo_rst) |=> (!out_valid && !frame_drop));
   // R2: an end marker only travels with data
   a_r2_eof_has_data: assert property (@(posedge clk) disable iff (!rst_n)
      out_eof |-> out_valid);
   // R3: the trailing byte of a two-byte-mode frame comes out two cycles late
   a_r3_lag_then_last: assert property (@(posedge clk) disable iff (!rst_n)
      (st == FS_PASS2 && cont && in_eof) |=> (out_valid && !out_eof));
   a_r3_flush_last: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_q && !fifo_rst) |=> (out_valid && out_eof));
endmodule

// File: rtl/hdlc_addr_filter.sv
module hdlc_addr_filter #(
   parameter int BYTE_W   = 8,
   parameter bit SEVEN_EN = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rx_enable,
   input  logic                rx_clk_en,
   input  logic                fifo_rst,
   input  logic                addr_rec_en,
   input  logic                seven_mode,
   input  logic [2*BYTE_W-1:0] uniq_addr,
   input  logic                in_valid,
   input  logic [BYTE_W-1:0]   in_data,
   input  logic                in_sof,
   input  logic                in_eof,
   output logic                out_valid,
   output logic [BYTE_W-1:0]   out_data,
   output logic                out_eof,
   output logic                frame_drop,
   output logic                fifo_flush,
   output logic                rx_active
);
   generate
      if (BYTE_W < 2) begin : g_bad_width
         $error("hdlc_addr_filter: BYTE_W must be at least 2");
      end
   endgenerate

   logic one_byte, first_ok, lo_uniq, lo_all, hi_uniq, hi_all;
   logic hold_q, busy, start;

   adf_match #(.BYTE_W(BYTE_W), .SEVEN_EN(SEVEN_EN)) u_match (
      .addr_rec_en (addr_rec_en),
      .seven_mode  (seven_mode),
      .uniq_addr   (uniq_addr),
      .d           (in_data),
      .one_byte    (one_byte),
      .first_ok    (first_ok),
      .lo_uniq     (lo_uniq),
      .lo_all      (lo_all),
      .hi_uniq     (hi_uniq),
      .hi_all      (hi_all)
   );

   adf_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .fifo_rst  (fifo_rst),
      .start     (start),
      .rx_enable (rx_enable),
      .busy      (busy),
      .hold_q    (hold_q),
      .rx_active (rx_active)
   );

   adf_frame #(.BYTE_W(BYTE_W)) u_frame (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .rx_clk_en  (rx_clk_en),
      .fifo_rst   (fifo_rst),
      .rx_enable  (rx_enable),
      .hold_q     (hold_q),
      .in_sof     (in_sof),
      .in_eof     (in_eof),
      .in_data    (in_data),
      .one_byte   (one_byte),
      .first_ok   (first_ok),
      .lo_uniq    (lo_uniq),
      .lo_all     (lo_all),
      .hi_uniq    (hi_uniq),
      .hi_all     (hi_all),
      .out_valid  (out_valid),
      .out_data   (out_data),
      .out_eof    (out_eof),
      .frame_drop (frame_drop),
      .fifo_flush (fifo_flush),
      .busy       (busy),
      .start      (start)
   );
endmodule

// File: tb/tb_hdlc_addr_filter.sv
module tb_hdlc_addr_filter;
   localparam int BW = 8;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic rst_n = 1'b0;
   logic rx_enable = 1'b1, rx_clk_en = 1'b1, fifo_rst = 1'b0;
   logic addr_rec_en = 1'b0, seven_mode = 1'b0;
   logic [2*BW-1:0] uniq_addr = 16'h3C5B;
   logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
   logic [BW-1:0] in_data = '0;
   logic out_valid, out_eof, frame_drop, fifo_flush, rx_active;
   logic [BW-1:0] out_data;

   hdlc_addr_filter #(.BYTE_W(BW)) dut (.*);

   int n_chk = 0, n_bad = 0;
   int n_out = 0, n_drop = 0, n_flush = 0;
   string req = "R1";
   bit finished = 1'b0;

   task automatic chk(input bit ok, input string r, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
      end
   endtask

   // reference model: queue-based, stepped on each rising edge
   int m_st = 0;
   bit m_hold = 0, m_mu = 0, m_ma = 0;
   logic [8:0] mq[$];
   bit e_v = 0, e_e = 0, e_dr = 0, e_fl = 0;
   logic [7:0] e_d = 0;

   task automatic m_emit(input logic [7:0] d, input bit e);
      e_v = 1; e_d = d; e_e = e;
   endtask

   task automatic m_drop();
      e_dr = 1; mq.delete(); m_st = in_eof ? 0 : 4;
   endtask

   task automatic m_byte();
      bit ok;
      logic [8:0] h;
      if (in_sof) begin
         if (!rx_enable) begin m_st = 0; mq.delete(); return; end
         m_hold = 0; mq.delete();
         if (!addr_rec_en || seven_mode) begin
            ok = !addr_rec_en ||
                 (in_data[0] && (in_data[7:1] == uniq_addr[7:1] || in_data[7:1] == 7'h7F));
            if (ok) begin m_emit(in_data, in_eof); m_st = in_eof ? 0 : 1; end
            else m_drop();
         end else begin
            m_mu = (in_data == uniq_addr[7:0]);
            m_ma = (in_data == 8'hFF);
            if ((m_mu || m_ma) && !in_eof) begin mq.push_back({1'b0, in_data}); m_st = 2; end
            else m_drop();
         end
      end else if (m_st != 0 && !m_hold) begin
         case (m_st)
            1: begin m_emit(in_data, in_eof); if (in_eof) m_st = 0; end
            2, 3: begin
               ok = (m_st == 3) || (m_mu && in_data == uniq_addr[15:8]) ||
                    (m_ma && in_data == 8'hFF);
               if (ok) begin
                  mq.push_back({in_eof, in_data});
                  h = mq.pop_front();
                  m_emit(h[7:0], 1'b0);
                  m_st = in_eof ? 0 : 3;
               end else m_drop();
            end
            default: if (in_eof) m_st = 0;
         endcase
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0; m_hold = 0; mq.delete();
         e_v = 0; e_e = 0; e_dr = 0; e_fl = 0;
      end else begin
         e_v = 0; e_e = 0; e_dr = 0; e_fl = 0;
         if (fifo_rst) begin
            m_st = 0; mq.delete(); m_hold = 1; e_fl = 1;
         end else if (mq.size() == 1 && mq[0][8]) begin
            m_emit(mq[0][7:0], 1'b1); mq.delete();
         end else if (in_valid && rx_clk_en) begin
            m_byte();
         end
      end
   end

   // every-cycle comparison at the falling edge
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         logic [12:0] act, exp;
         bit e_act;
         e_act = !m_hold && (rx_enable || m_st != 0);
         act = {out_valid, out_valid ? out_eof : 1'b0, frame_drop, fifo_flush, rx_active,
                out_valid ? out_data : 8'h00};
         exp = {e_v, e_v ? e_e : 1'b0, e_dr, e_fl, e_act, e_v ? e_d : 8'h00};
         chk(act == exp, req, "cycle outputs {v,eof,drop,flush,act,data}", act, exp);
         if (out_valid)  n_out++;
         if (frame_drop) n_drop++;
         if (fifo_flush) n_flush++;
      end
   end

   task automatic tick(); @(posedge clk); #2; endtask

   task automatic put(input logic [7:0] d, input bit s, input bit e, input bit ce);
      tick();
      in_valid = 1; in_data = d; in_sof = s; in_eof = e; rx_clk_en = ce;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         tick();
         in_valid = 0; in_sof = 0; in_eof = 0; rx_clk_en = 1;
      end
   endtask

   task automatic frame3(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
      put(a, 1, 0, 1); put(b, 0, 0, 1); put(c, 0, 1, 1); idle(4);
   endtask

   task automatic frame2(input logic [7:0] a, input logic [7:0] b);
      put(a, 1, 0, 1); put(b, 0, 1, 1); idle(4);
   endtask

   task automatic clr(input string r);
      req = r; n_out = 0; n_drop = 0; n_flush = 0;
   endtask

   task automatic counts(input string r, input int bytes, input int drops);
      chk(n_out == bytes, r, "bytes written", n_out, bytes);
      chk(n_drop == drops, r, "discard pulses", n_drop, drops);
   endtask

   task automatic summary();
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=1 expected=0");
         summary();
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(!out_valid && !out_eof && !frame_drop && !fifo_flush, "R1", "outputs idle",
          {out_valid, out_eof, frame_drop, fifo_flush}, 0);
      chk(rx_active == rx_enable, "R1", "rx_active", rx_active, rx_enable);

      // R2: recognition off passes everything
      clr("R2"); frame3(8'h12, 8'h34, 8'h56); counts("R2", 3, 0);

      // R3: two-byte station and all-call
      addr_rec_en = 1;
      clr("R3"); put(8'h5B,1,0,1); put(8'h3C,0,0,1); put(8'h01,0,0,1); put(8'h02,0,1,1); idle(4);
      counts("R3", 4, 0);
      clr("R3"); frame3(8'hFF, 8'hFF, 8'h09); counts("R3", 3, 0);
      clr("R3"); frame2(8'h5B, 8'h3C); counts("R3", 2, 0);

      // R5: second byte mismatch
      clr("R5"); frame3(8'h5B, 8'h3D, 8'h07); counts("R5", 0, 1);
      // R6: mixed targets, and first-byte miss
      clr("R6"); frame3(8'h5B, 8'hFF, 8'h07); counts("R6", 0, 1);
      clr("R6"); frame3(8'h11, 8'h3C, 8'h07); counts("R6", 0, 1);

      // R10: gated byte in an accepted two-byte frame
      clr("R10"); put(8'h5B,1,0,1); put(8'h3C,0,0,1); put(8'hAA,0,0,0); put(8'hBB,0,1,1); idle(4);
      counts("R10", 3, 0);

      // R4: seven-bit mode
      seven_mode = 1;
      clr("R4"); frame3(8'h5B, 8'h07, 8'h08); counts("R4", 3, 0);
      clr("R4"); frame3(8'h5A, 8'h07, 8'h08); counts("R4", 0, 1);
      clr("R4"); frame2(8'hFF, 8'h01); counts("R4", 2, 0);
      clr("R4"); frame3(8'h5F, 8'h07, 8'h08); counts("R4", 0, 1);
      seven_mode = 0; addr_rec_en = 0;

      // R7: disable mid-frame
      clr("R7");
      put(8'h21,1,0,1); put(8'h22,0,0,1); rx_enable = 0; put(8'h23,0,1,1); idle(2);
      @(negedge clk);
      chk(rx_active == 0, "R7", "rx_active after frame", rx_active, 0);
      frame2(8'h31, 8'h32);
      counts("R7", 3, 0);

      // R8: enable takes effect at once
      tick(); rx_enable = 1; #3;
      chk(rx_active == 1, "R8", "rx_active same cycle", rx_active, 1);
      idle(2);

      // R9: FIFO reset mid-frame
      clr("R9");
      put(8'h41,1,0,1); put(8'h42,0,0,1); idle(1);
      tick(); fifo_rst = 1; tick(); fifo_rst = 0;
      put(8'h43,0,0,1); put(8'h44,0,1,1); idle(2);
      @(negedge clk);
      chk(rx_active == 0, "R9", "rx_active muted", rx_active, 0);
      chk(n_flush == 1, "R9", "flush pulses", n_flush, 1);
      counts("R9", 2, 0);
      clr("R9"); frame2(8'h51, 8'h52); counts("R9", 2, 0);
      @(negedge clk);
      chk(rx_active == 1, "R9", "rx_active after opening byte", rx_active, 1);

      idle(3);
      summary();
   end
endmodule